// File: doc/BRIEF.md
# Split-Region Row/Column Address Mapper

This block turns a flat block address into a DRAM row index and column index for an array that is divided by row into two regions. Rows below a programmable boundary make up the plain (unprotected) region; rows at or above it make up the ECC-protected region. Because the boundary is arbitrary, either region can hold a row count that is not a power of two. A single magnitude compare against the plain-region capacity (boundary rows times column count) picks the region. An ECC-region address is rebased by subtracting that capacity, and the boundary row count is added back onto the local row. No divider appears anywhere in the path.

Each request carries a mode bit. Page mode keeps consecutive addresses inside one row. Line mode spreads consecutive addresses across rows for parallelism. Line mode is honoured only when the selected region's row count is a power of two. Otherwise the request falls back to page mode and a fallback flag is raised. Results are registered with one cycle of latency. The boundary value is taken in only during idle cycles, so requests already accepted are never remapped mid-flight.

Top module: `pamap_top`

## Requirements
- R1: With effective boundary B, an in-range address below B·COLS is reported with out_ecc=0 and a row below B. An in-range address at or above B·COLS is reported with out_ecc=1 and a row at or above B.
- R2: In page mode (in_mode=0) the column is the low COL_W bits of the region-local address and the local row is the remaining upper bits. For example, with B=6, address 47 maps to row 5, column 7.
- R3: In line mode (in_mode=1) on a region of n rows, where n is a power of two, the local row is the local address modulo n and the column is the local address divided by n. For example, with B=8, address 49 maps to row 1, column 6.
- R4: For an ECC-region address, the local address is the address minus B·COLS, and the reported row is the local row plus B.
- R5: A line-mode request to a region whose row count is not a power of two is mapped as in page mode and reports out_fallback=1. Every other request reports out_fallback=0.
- R6: An address of ROWS·COLS or more (its top bit set) reports out_oor=1, with out_row, out_col, out_ecc and out_fallback all 0.
- R7: out_valid is high exactly one cycle after each cycle with in_valid high, and the results belong to that request.
- R8: cfg_bnd is loaded only at clock edges where in_valid is low. Values presented while in_valid is high have no effect on any mapping until an idle cycle.
- R9: A cfg_bnd value above ROWS is treated as ROWS, so the whole array is the plain region.
- R10: After reset, out_valid and all result outputs are 0, and the effective boundary is ROWS until the first idle-cycle load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_addr | input | ROW_W+COL_W+1 | Flat block address; the top bit marks out of range |
| in_mode | input | 1 | 0 = page mode, 1 = line mode |
| cfg_bnd | input | ROW_W+1 | Requested count of plain-region rows |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_ecc | output | 1 | Address lies in the ECC region |
| out_row | output | ROW_W | Row index |
| out_col | output | COL_W | Column index |
| out_fallback | output | 1 | Line mode was requested but page mode was used |
| out_oor | output | 1 | Address is outside the array |

## Verification
The bench sweeps every boundary value, including those above ROWS, in both modes, over every address in a space twice the array size. It checks each result against arithmetic computed with true division and modulo. A design that took the row from the low address bits on a six-row region would produce an 8×6 shape, and rows 6 and 7 would appear among plain-region results. A missing rebase subtraction or a dropped row offset would put ECC-region traffic on the wrong rows. A mis-built power-of-two test would either raise fallback on two- and four-row regions or interleave across a six-row region. During every sweep, a different boundary value is driven while requests stream. A mapper that loaded it would remap half of each pass. The reset check sends a request on the first edge after reset to expose a wrong initial boundary.

// File: rtl/pamap_pkg.sv
package pamap_pkg;
   typedef enum logic {
      MAP_PAGE = 1'b0,
      MAP_LINE = 1'b1
   } map_mode_e;
endpackage

// File: rtl/pamap_bound_reg.sv
// Holds the effective row boundary; loads only in idle cycles.
module pamap_bound_reg #(
   parameter int ROW_W = 3,
   parameter int COL_W = 3,
   parameter bit CLAMP = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               busy,
   input  logic [ROW_W:0]     cfg_bnd,
   output logic [ROW_W:0]     bnd_rows,
   output logic [ROW_W:0]     ecc_rows,
   output logic [ROW_W+COL_W:0] cap_lo
);
   localparam logic [ROW_W:0] ROWS_V = {1'b1, {ROW_W{1'b0}}};

   logic [ROW_W:0] bnd_in;
   logic [ROW_W:0] bnd_q;

   generate
      if (CLAMP) begin : g_clamp
         always_comb bnd_in = (cfg_bnd > ROWS_V) ? ROWS_V : cfg_bnd;
      end else begin : g_pass
         always_comb bnd_in = cfg_bnd;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    bnd_q <= ROWS_V;
      else if (!busy) bnd_q <= bnd_in;
   end

   assign bnd_rows = bnd_q;
   assign ecc_rows = ROWS_V - bnd_q;
   assign cap_lo   = {bnd_q, {COL_W{1'b0}}};

   AST_BND_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(bnd_q)); // R8
   AST_BND_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> (bnd_q <= ROWS_V)); // R9
endmodule

// File: rtl/pamap_region_sel.sv
// Region comparator and rebase subtractor.
module pamap_region_sel #(
   parameter int ROW_W = 3,
   parameter int COL_W = 3
) (
   input  logic [ROW_W+COL_W:0]   addr,
   input  logic [ROW_W:0]         bnd_rows,
   input  logic [ROW_W:0]         ecc_rows,
   input  logic [ROW_W+COL_W:0]   cap_lo,
   output logic                   oor,
   output logic                   in_ecc,
   output logic [ROW_W:0]         reg_rows,
   output logic [ROW_W-1:0]       row_off,
   output logic [ROW_W+COL_W-1:0] local_addr
);
   localparam int ADDR_W = ROW_W + COL_W;

   always_comb begin
      oor        = addr[ADDR_W];
      in_ecc     = !oor && (addr >= cap_lo);
      local_addr = addr[ADDR_W-1:0]
                 - (in_ecc ? cap_lo[ADDR_W-1:0] : {ADDR_W{1'b0}});
      reg_rows   = in_ecc ? ecc_rows : bnd_rows;
      row_off    = in_ecc ? bnd_rows[ROW_W-1:0] : {ROW_W{1'b0}};
   end
endmodule

// File: rtl/pamap_split.sv
// Splits a region-local address into row and column, shift/mask only.
module pamap_split
   import pamap_pkg::*;
#(
   parameter int ROW_W   = 3,
   parameter int COL_W   = 3,
   parameter bit LINE_EN = 1'b1
) (
   input  logic [ROW_W+COL_W-1:0] local_addr,
   input  logic [ROW_W:0]         reg_rows,
   input  map_mode_e              mode,
   output logic [ROW_W-1:0]       lrow,
   output logic [COL_W-1:0]       lcol,
   output logic                   fallback
);
   localparam int ADDR_W = ROW_W + COL_W;
   localparam int KW     = $clog2(ROW_W + 2);

   logic            is_pow2;
   logic [KW-1:0]   shamt;
   logic            use_line;
   logic [ADDR_W-1:0] row_mask;

   always_comb begin
      is_pow2 = (reg_rows != '0) && ((reg_rows & (reg_rows - 1'b1)) == '0);
      shamt   = '0;
      for (int i = 0; i <= ROW_W; i++) begin
         if (reg_rows[i]) shamt = KW'(i);
      end
      row_mask = ADDR_W'(reg_rows - 1'b1);
   end

   generate
      if (LINE_EN) begin : g_line
         always_comb begin
            use_line = (mode == MAP_LINE) && is_pow2;
            fallback = (mode == MAP_LINE) && !is_pow2;
         end
      end else begin : g_page_only
         always_comb begin
            use_line = 1'b0;
            fallback = (mode == MAP_LINE);
         end
      end
   endgenerate

   always_comb begin
      if (use_line) begin
         lrow = ROW_W'(local_addr & row_mask);
         lcol = COL_W'(local_addr >> shamt);
      end else begin
         lrow = local_addr[ADDR_W-1:COL_W];
         lcol = local_addr[COL_W-1:0];
      end
   end
endmodule

// File: rtl/pamap_top.sv
module pamap_top
   import pamap_pkg::*;
#(
   parameter int ROW_W   = 3,
   parameter int COL_W   = 3,
   parameter bit LINE_EN = 1'b1,
   parameter bit CLAMP   = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [ROW_W+COL_W:0]   in_addr,
   input  logic                   in_mode,
   input  logic [ROW_W:0]         cfg_bnd,
   output logic                   out_valid,
   output logic                   out_ecc,
   output logic [ROW_W-1:0]       out_row,
   output logic [COL_W-1:0]       out_col,
   output logic                   out_fallback,
   output logic                   out_oor
);
   localparam int ADDR_W = ROW_W + COL_W;

   generate
      if (ROW_W < 1 || COL_W < 1) begin : g_bad_dims
         $error("pamap_top: ROW_W and COL_W must be at least 1");
      end
      if (ADDR_W > 30) begin : g_bad_addr
         $error("pamap_top: address too wide");
      end
   endgenerate

   logic [ROW_W:0]    bnd_rows;
   logic [ROW_W:0]    ecc_rows;
   logic [ADDR_W:0]   cap_lo;
   logic              oor;
   logic              in_ecc;
   logic [ROW_W:0]    reg_rows;
   logic [ROW_W-1:0]  row_off;
   logic [ADDR_W-1:0] local_addr;
   logic [ROW_W-1:0]  lrow;
   logic [COL_W-1:0]  lcol;
   logic              fallback;
   map_mode_e         mode;

   assign mode = map_mode_e'(in_mode);

   pamap_bound_reg #(.ROW_W(ROW_W), .COL_W(COL_W), .CLAMP(CLAMP)) i_bound (
      .clk      (clk),
      .rst_n    (rst_n),
      .busy     (in_valid),
      .cfg_bnd  (cfg_bnd),
      .bnd_rows (bnd_rows),
      .ecc_rows (ecc_rows),
      .cap_lo   (cap_lo)
   );

   pamap_region_sel #(.ROW_W(ROW_W), .COL_W(COL_W)) i_sel (
      .addr       (in_addr),
      .bnd_rows   (bnd_rows),
      .ecc_rows   (ecc_rows),
      .cap_lo     (cap_lo),
      .oor        (oor),
      .in_ecc     (in_ecc),
      .reg_rows   (reg_rows),
      .row_off    (row_off),
      .local_addr (local_addr)
   );

   pamap_split #(.ROW_W(ROW_W), .COL_W(COL_W), .LINE_EN(LINE_EN)) i_split (
      .local_addr (local_addr),
      .reg_rows   (reg_rows),
      .mode       (mode),
      .lrow       (lrow),
      .lcol       (lcol),
      .fallback   (fallback)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_ecc      <= 1'b0;
         out_row      <= '0;
         out_col      <= '0;
         out_fallback <= 1'b0;
         out_oor      <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_oor <= oor;
            if (oor) begin
               out_ecc      <= 1'b0;
               out_row      <= '0;
               out_col      <= '0;
               out_fallback <= 1'b0;
            end else begin
               out_ecc      <= in_ecc;
               out_row      <= lrow + row_off;
               out_col      <= lcol;
               out_fallback <= fallback;
            end
         end
      end
   end

   AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R7
   AST_IDLE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R7
   AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_addr[ADDR_W]) |=> (out_oor && out_row == '0 && out_col == '0
                                         && !out_ecc && !out_fallback)); // R6
   AST_ECC_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ecc) |-> ({1'b0, out_row} >= bnd_rows)); // R1
   AST_PLAIN_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_oor && !out_ecc) |-> ({1'b0, out_row} < bnd_rows)); // R1
   AST_FB_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_mode) |=> !out_fallback); // R5
endmodule

// File: tb/test_pamap_top.sv
module test_pamap_top;
   localparam int ROW_W = 3;
   localparam int COL_W = 3;
   localparam int ROWS  = 1 << ROW_W;
   localparam int COLS  = 1 << COL_W;
   localparam int AW    = ROW_W + COL_W + 1;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             in_valid;
   logic [AW-1:0]    in_addr;
   logic             in_mode;
   logic [ROW_W:0]   cfg_bnd;
   logic             out_valid;
   logic             out_ecc;
   logic [ROW_W-1:0] out_row;
   logic [COL_W-1:0] out_col;
   logic             out_fallback;
   logic             out_oor;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   pamap_top #(.ROW_W(ROW_W), .COL_W(COL_W)) i_pamap_top (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
      .in_mode(in_mode), .cfg_bnd(cfg_bnd), .out_valid(out_valid),
      .out_ecc(out_ecc), .out_row(out_row), .out_col(out_col),
      .out_fallback(out_fallback), .out_oor(out_oor)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Compares one mapped result against arithmetic expectations.
   task automatic chk_map(input int a, input int m, input int b);
      int  ecc, n, loc, row, col, fb, oor;
      bit  p2;
      string tag;
      oor = 0; ecc = 0; row = 0; col = 0; fb = 0;
      if (a >= ROWS * COLS) begin
         oor = 1; tag = "R6";
      end else begin
         ecc = (a >= b * COLS) ? 1 : 0;
         n   = ecc ? (ROWS - b) : b;
         loc = ecc ? (a - b * COLS) : a;
         p2  = (n != 0) && ((n & (n - 1)) == 0);
         if (m == 1 && p2) begin
            row = loc % n; col = loc / n; tag = "R3";
         end else begin
            row = loc / COLS; col = loc % COLS; tag = (m == 1) ? "R5" : "R2";
         end
         fb = (m == 1 && !p2) ? 1 : 0;
         if (ecc) begin
            row = row + b; tag = {tag, "/R4"};
         end
         tag = {tag, "/R1"};
      end
      if (b == ROWS) tag = {tag, "/R9"};
      tag = $sformatf("%s/R8 a=%0d m=%0d b=%0d", tag, a, m, b);
      n_tests++;
      if (out_valid !== 1'b1 || out_oor !== oor[0] || out_ecc !== ecc[0]
          || int'(out_row) != row || int'(out_col) != col || out_fallback !== fb[0]) begin
         n_fail++;
         $display("FAIL %s: actual v=%0b oor=%0b ecc=%0b row=%0d col=%0d fb=%0b expected v=1 oor=%0d ecc=%0d row=%0d col=%0d fb=%0d",
                  tag, out_valid, out_oor, out_ecc, out_row, out_col, out_fallback,
                  oor, ecc, row, col, fb);
      end
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n    = 1'b0;
      in_valid = 1'b1;
      in_addr  = AW'(60);
      in_mode  = 1'b0;
      cfg_bnd  = 4'd2;
      repeat (3) @(negedge clk);
      // R10: outputs cleared while in reset
      chk("R10 out_valid in reset", int'(out_valid), 0);
      chk("R10 out_row in reset", int'(out_row), 0);
      chk("R10 out_ecc in reset", int'(out_ecc), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: boundary starts at ROWS, so address 60 is plain, row 7 col 4
      chk("R10 first valid", int'(out_valid), 1);
      chk("R10 first ecc", int'(out_ecc), 0);
      chk("R10 first row", int'(out_row), 7);
      chk("R10 first col", int'(out_col), 4);
      in_valid = 1'b0;
      @(negedge clk);
      chk("R7 idle gives no valid", int'(out_valid), 0);

      for (int b = 0; b < 16; b++) begin
         for (int m = 0; m < 2; m++) begin
            in_valid = 1'b0;
            cfg_bnd  = 4'(b);
            @(negedge clk);
            for (int a = 0; a < (1 << AW); a++) begin
               in_valid = 1'b1;
               in_addr  = AW'(a);
               in_mode  = m[0];
               cfg_bnd  = 4'(b ^ 5);   // R8: must be ignored while busy
               @(negedge clk);
               chk_map(a, m, (b > ROWS) ? ROWS : b);
            end
         end
      end

      // R3: full space, line mode, address 49 -> row 1 col 6
      in_valid = 1'b0; cfg_bnd = 4'd8; @(negedge clk);
      in_valid = 1'b1; in_addr = AW'(49); in_mode = 1'b1; @(negedge clk);
      chk("R3 addr49 row", int'(out_row), 1);
      chk("R3 addr49 col", int'(out_col), 6);
      // R2/R5: 3:1 split, six plain rows, line falls back; 47 -> row 5 col 7
      in_valid = 1'b0; cfg_bnd = 4'd6; @(negedge clk);
      in_valid = 1'b1; in_addr = AW'(47); in_mode = 1'b1; @(negedge clk);
      chk("R2 addr47 row", int'(out_row), 5);
      chk("R2 addr47 col", int'(out_col), 7);
      chk("R5 addr47 fallback", int'(out_fallback), 1);
      in_valid = 1'b0;
      @(negedge clk);
      chk("R7 valid drops after stream", int'(out_valid), 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule